// File: doc/BRIEF.md
# Memory Zero-Fill Engine

The engine writes a fixed fill word over a region of memory when it is told to start. A region is either a naturally aligned block whose byte size is two raised to a given exponent, or, when the whole-memory flag is set, the full configured capacity. The start command carries three pieces. The first is a control word that holds the size exponent and the whole-memory flag. The second is the low 32 bits of a 38-bit byte address. The third is the high 6 bits of that address. A fill word comes with the command and is normally zero.

On each start the engine answers one cycle later with a response pulse. The response has an accept bit and a 3-bit error code. When the command is accepted, the engine issues ascending burst-sized write requests on a valid/ready memory port, one burst per accepted transfer. After the last transfer it raises a done status bit, and software polls that bit. A rejected command produces no writes.

Top module: `meminit_engine`

## Requirements
- R1: After reset, `done`, `busy`, `wr_valid` and `resp_valid` are all low.
- R2: A `start` sampled at a clock edge produces `resp_valid` high for the next cycle. On acceptance, `resp_accept`=1 and `resp_code`=0. On rejection, `resp_accept`=0 and `resp_code` is nonzero.
- R3: In range mode (`cmd_ctrl[6]`=0), the size exponent is `cmd_ctrl[5:0]`. The writes cover base through base+2^exp-1 in ascending order. The address steps by 2^BURST_LOG2 bytes per accepted transfer, and there are 2^(exp-BURST_LOG2) transfers in total.
- R4: With `cmd_ctrl[6]`=1, the engine writes addresses 0 up to 2^CAP_LOG2-1. In this mode it ignores the exponent and both address words.
- R5: The start address is {`cmd_addr_hi[5:0]`, `cmd_addr_lo[31:0]`}, so the high word supplies bits 37:32.
- R6: In range mode, a base that is not a multiple of 2^exp is rejected with code 2 and causes no writes.
- R7: In range mode, a region whose exponent exceeds CAP_LOG2, or whose base lies at or above 2^CAP_LOG2, is rejected with code 3 and causes no writes.
- R8: In range mode, an exponent below BURST_LOG2 is rejected with code 4. The checks apply in this priority order: busy (code 1), then code 4, then code 2, then code 3.
- R9: A start while `busy` is high is rejected with code 1. The ongoing run continues unchanged. This also holds for a start in the same cycle as the final transfer.
- R10: `done` rises in the cycle after the final accepted transfer and stays high while idle. It clears in the same cycle that an accepted response appears. A rejected start leaves it unchanged.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold steady. `wr_data` equals the fill word latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command strobe |
| cmd_ctrl | input | 7 | [5:0] size exponent, [6] whole-memory flag |
| cmd_addr_lo | input | 32 | Start address bits 31:0 |
| cmd_addr_hi | input | 6 | Start address bits 37:32 |
| cmd_fill | input | 32 | Fill word |
| resp_valid | output | 1 | Response pulse, one cycle after start |
| resp_accept | output | 1 | Command accepted |
| resp_code | output | 3 | Error code (0 none, 1 busy, 2 misaligned, 3 out of range, 4 too small) |
| busy | output | 1 | Fill in progress |
| done | output | 1 | Fill complete status |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted by memory |
| wr_addr | output | 38 | Write byte address (burst aligned) |
| wr_data | output | 32 | Write fill word |

## Verification
A new start can arrive in the same cycle that the memory accepts the final burst of a run. In that cycle the run's completion and the admission decision for the new command coincide. The bench provokes this by raising `start` and `wr_ready` together on the last pending transfer. It expects a busy rejection (code 1), a `done` that rises regardless, and no further writes. A second start then follows, and the bench judges that `done` clears on its acceptance and that only the new region is written.

// File: rtl/meminit_pkg.sv
package meminit_pkg;

    localparam int ADDR_W = 38;
    localparam int FILL_W = 32;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_BUSY  = 3'd1,
        ERR_ALIGN = 3'd2,
        ERR_RANGE = 3'd3,
        ERR_SMALL = 3'd4
    } err_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [5:0]        exp;
        logic              whole;
        logic [FILL_W-1:0] fill;
    } req_t;

    function automatic req_t pack_req(input logic [6:0]        ctrl,
                                      input logic [31:0]       lo,
                                      input logic [5:0]        hi,
                                      input logic [FILL_W-1:0] fill);
        req_t r;
        r.base  = {hi, lo};
        r.exp   = ctrl[5:0];
        r.whole = ctrl[6];
        r.fill  = fill;
        return r;
    endfunction

endpackage

// File: rtl/meminit_admit.sv
module meminit_admit
    import meminit_pkg::*;
#(
    parameter int CAP_LOG2   = 16,
    parameter int BURST_LOG2 = 4
) (
    input  req_t              req,
    input  logic              busy,
    output err_e              err,
    output logic [ADDR_W-1:0] eff_base,
    output logic [5:0]        eff_exp
);
    localparam logic [5:0] CAP_E   = 6'(CAP_LOG2);
    localparam logic [5:0] BURST_E = 6'(BURST_LOG2);

    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            low_mask[i] = (6'(i) < req.exp);
        end
    end

    always_comb begin
        eff_base = req.whole ? '0 : req.base;
        eff_exp  = req.whole ? CAP_E : req.exp;
        if (busy)
            err = ERR_BUSY;
        else if (req.whole)
            err = ERR_NONE;
        else if (req.exp < BURST_E)
            err = ERR_SMALL;
        else if ((req.base & low_mask) != '0)
            err = ERR_ALIGN;
        else if (req.exp > CAP_E || (req.base >> CAP_LOG2) != '0)
            err = ERR_RANGE;
        else
            err = ERR_NONE;
    end

endmodule

// File: rtl/meminit_walk.sv
module meminit_walk
    import meminit_pkg::*;
#(
    parameter int CAP_LOG2   = 16,
    parameter int BURST_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [5:0]        load_exp,
    input  logic [FILL_W-1:0] load_fill,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [FILL_W-1:0] wr_data
);
    localparam int                CNT_W   = CAP_LOG2 - BURST_LOG2 + 1;
    localparam logic [5:0]        BURST_E = 6'(BURST_LOG2);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(1) << BURST_LOG2;

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            remain  <= '0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            remain  <= CNT_W'(1) << (load_exp - BURST_E);
            wr_addr <= load_base;
            wr_data <= load_fill;
        end else if (busy && wr_ready) begin
            wr_addr <= wr_addr + STEP;
            remain  <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assign wr_valid = busy;

endmodule

// File: rtl/meminit_engine.sv
module meminit_engine
    import meminit_pkg::*;
#(
    parameter int CAP_LOG2   = 16,
    parameter int BURST_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [6:0]        cmd_ctrl,
    input  logic [31:0]       cmd_addr_lo,
    input  logic [5:0]        cmd_addr_hi,
    input  logic [31:0]       cmd_fill,
    output logic              resp_valid,
    output logic              resp_accept,
    output logic [2:0]        resp_code,
    output logic              busy,
    output logic              done,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [37:0]       wr_addr,
    output logic [31:0]       wr_data
);
    req_t              req;
    err_e              err;
    logic [ADDR_W-1:0] eff_base;
    logic [5:0]        eff_exp;
    logic              load;

    assign req  = pack_req(cmd_ctrl, cmd_addr_lo, cmd_addr_hi, cmd_fill);
    assign load = start && (err == ERR_NONE);

    meminit_admit #(.CAP_LOG2(CAP_LOG2), .BURST_LOG2(BURST_LOG2)) u_admit (
        .req      (req),
        .busy     (busy),
        .err      (err),
        .eff_base (eff_base),
        .eff_exp  (eff_exp)
    );

    meminit_walk #(.CAP_LOG2(CAP_LOG2), .BURST_LOG2(BURST_LOG2)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_base (eff_base),
        .load_exp  (eff_exp),
        .load_fill (req.fill),
        .wr_ready  (wr_ready),
        .busy      (busy),
        .done      (done),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
            resp_code   <= 3'd0;
        end else begin
            resp_valid  <= start;
            resp_accept <= load;
            resp_code   <= start ? err : ERR_NONE;
        end
    end

endmodule

// File: rtl/meminit_engine_chk.sv
module meminit_engine_chk #(
    parameter int CAP_LOG2   = 16,
    parameter int BURST_LOG2 = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        resp_valid,
    input logic        resp_accept,
    input logic [2:0]  resp_code,
    input logic        busy,
    input logic        done,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [37:0] wr_addr,
    input logic [31:0] wr_data
);
    p_reject_code_r2: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_accept |-> resp_code != 3'd0);

    p_accept_starts_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_accept |-> busy && !done);

    p_reject_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_accept && resp_code != 3'd1 |-> !wr_valid);

    p_burst_align_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr & ((38'd1 << BURST_LOG2) - 38'd1)) == 38'd0);

    p_in_capacity_r7: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr >> CAP_LOG2) == 38'd0);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    p_done_after_last_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_valid && wr_ready));

endmodule

bind meminit_engine meminit_engine_chk #(.CAP_LOG2(CAP_LOG2), .BURST_LOG2(BURST_LOG2)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .resp_valid  (resp_valid),
    .resp_accept (resp_accept),
    .resp_code   (resp_code),
    .busy        (busy),
    .done        (done),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
);

// File: tb/meminit_engine_test.sv
module meminit_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 16;
    localparam int BURST      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  cmd_ctrl = '0;
    logic [31:0] cmd_addr_lo = '0;
    logic [5:0]  cmd_addr_hi = '0;
    logic [31:0] cmd_fill = '0;
    logic        resp_valid, resp_accept, busy, done, wr_valid;
    logic [2:0]  resp_code;
    logic        wr_ready = 1'b0;
    logic [37:0] wr_addr;
    logic [31:0] wr_data;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    meminit_engine #(.CAP_LOG2(CAP), .BURST_LOG2(BURST)) uut (
        .clk(clk), .rst(rst), .start(start), .cmd_ctrl(cmd_ctrl),
        .cmd_addr_lo(cmd_addr_lo), .cmd_addr_hi(cmd_addr_hi), .cmd_fill(cmd_fill),
        .resp_valid(resp_valid), .resp_accept(resp_accept), .resp_code(resp_code),
        .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct packed {
        logic [6:0]  ctrl;
        logic [31:0] lo;
        logic [5:0]  hi;
        logic [31:0] fill;
        logic        stall;
        logic [2:0]  code;
        logic [37:0] base;
        logic [15:0] n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{7'd8,           32'h100,  6'd0, 32'h0,        1'b0, 3'd0, 38'h100,  16'd16},   // R3
        '{7'd6,           32'h40,   6'd0, 32'hA5A5A5A5, 1'b1, 3'd0, 38'h40,   16'd4},    // R3 R11 stalls
        '{7'd8,           32'h180,  6'd0, 32'h0,        1'b0, 3'd2, 38'h0,    16'd0},    // R6
        '{7'd3,           32'h0,    6'd0, 32'h0,        1'b0, 3'd4, 38'h0,    16'd0},    // R8
        '{7'd17,          32'h0,    6'd0, 32'h0,        1'b0, 3'd3, 38'h0,    16'd0},    // R7
        '{7'd12,          32'hF000, 6'd1, 32'h0,        1'b0, 3'd3, 38'h0,    16'd0},    // R5 R7 high word
        '{7'd4,           32'hFFF0, 6'd0, 32'h5,        1'b0, 3'd0, 38'hFFF0, 16'd1},    // R3 top burst
        '{7'h43,          32'h123,  6'h2A, 32'h0,       1'b0, 3'd0, 38'h0,    16'd4096}  // R4 whole memory
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [6:0] c, input logic [31:0] lo, input logic [5:0] hi,
                         input logic [31:0] f);
        @(negedge clk);
        cmd_ctrl = c; cmd_addr_lo = lo; cmd_addr_hi = hi; cmd_fill = f;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic        prev_done;
        logic [37:0] a_prev;
        logic        hs;
        int          idx, cyc;
        string       tg;
        prev_done = done;
        tg = v.ctrl[6] ? "R4" : "R3";
        issue(v.ctrl, v.lo, v.hi, v.fill);
        chk(resp_valid == 1'b1, "R2 resp_valid", 64'(resp_valid), 64'd1);
        chk(resp_accept == (v.code == 3'd0), "R2 accept", 64'(resp_accept), 64'(v.code == 3'd0));
        chk(resp_code == v.code, "R2/R6/R7/R8 code", 64'(resp_code), 64'(v.code));
        if (v.code != 3'd0) begin
            for (int k = 0; k < 3; k++) begin
                chk(wr_valid == 1'b0, "R6/R7/R8 no write", 64'(wr_valid), 64'd0);
                chk(done == prev_done, "R10 done untouched", 64'(done), 64'(prev_done));
                @(negedge clk);
            end
        end else begin
            chk(done == 1'b0, "R10 done cleared", 64'(done), 64'd0);
            idx = 0; cyc = 0;
            while (busy && cyc < 20000) begin
                wr_ready = v.stall ? (cyc % 3 != 1) : 1'b1;
                a_prev = wr_addr;
                @(posedge clk);
                hs = wr_ready;
                @(negedge clk);
                if (hs) begin
                    chk(a_prev == v.base + (38'(idx) << BURST), tg, 64'(a_prev),
                        64'(v.base + (38'(idx) << BURST)));
                    chk(wr_data == v.fill, "R11 data", 64'(wr_data), 64'(v.fill));
                    idx++;
                end else begin
                    chk(wr_addr == a_prev, "R11 stall hold", 64'(wr_addr), 64'(a_prev));
                end
                cyc++;
            end
            wr_ready = 1'b0;
            chk(idx == int'(v.n), {tg, " transfer count"}, 64'(idx), 64'(v.n));
            chk(done == 1'b1, "R10 done set", 64'(done), 64'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(done == 0 && busy == 0 && wr_valid == 0 && resp_valid == 0, "R1 reset",
            {60'd0, done, busy, wr_valid, resp_valid}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: start while busy is rejected and the run is unaffected
        issue(7'd5, 32'h400, 6'd0, 32'h77);
        chk(resp_accept == 1'b1, "R2 accept", 64'(resp_accept), 64'd1);
        issue(7'd8, 32'h800, 6'd0, 32'h0);
        chk(resp_code == 3'd1 && !resp_accept, "R9 busy reject", 64'(resp_code), 64'd1);
        chk(wr_addr == 38'h400, "R9 run unchanged", 64'(wr_addr), 64'h400);
        chk(wr_data == 32'h77, "R9 fill unchanged", 64'(wr_data), 64'h77);
        wr_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(wr_addr == 38'h410, "R9 second burst", 64'(wr_addr), 64'h410);
        @(posedge clk); @(negedge clk);
        wr_ready = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R10 done after run", 64'(done), 64'd1);

        // R9/R10: start in the same cycle as the final transfer
        issue(7'd4, 32'h200, 6'd0, 32'h11);
        chk(resp_accept == 1'b1 && done == 1'b0, "R10 clear on accept", 64'(done), 64'd0);
        cmd_ctrl = 7'd4; cmd_addr_lo = 32'h300; cmd_fill = 32'h22;
        start = 1'b1; wr_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0; wr_ready = 1'b0;
        chk(resp_valid && !resp_accept && resp_code == 3'd1, "R9 same-cycle reject",
            64'(resp_code), 64'd1);
        chk(done == 1'b1 && busy == 1'b0, "R10 done same cycle", 64'(done), 64'd1);
        repeat (2) @(negedge clk);
        chk(done == 1'b1 && wr_valid == 1'b0, "R10 done holds idle", 64'(done), 64'd1);
        issue(7'd4, 32'h300, 6'd0, 32'h22);
        chk(resp_accept == 1'b1 && done == 1'b0, "R10 clear on accept", 64'(done), 64'd0);
        chk(wr_addr == 38'h300 && wr_data == 32'h22, "R3 new region", 64'(wr_addr), 64'h300);
        wr_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_ready = 1'b0;
        chk(done == 1'b1 && wr_valid == 1'b0, "R10 single burst done", 64'(done), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule